// File: doc/BRIEF.md
# Wear-Levelling Block Mapper

This block keeps the logical-to-physical block map for a small flash array and decides where each write lands. A write never goes back into the physical block it replaces. The block steers it instead to the least-worn free physical block. The old copy is then erased, and that block goes back to the free pool. Per-block erase counters drive every choice the block makes.

A second mechanism handles data that is rarely rewritten. On a periodic tick, the block measures the spread between the most-worn free block and the least-worn block holding data. If that spread is larger than a programmable threshold, the cold data is copied into the worn free block. The cold block is then erased and becomes available to ordinary writes.

Blocks that reach the endurance limit are retired for good. When no usable free block is left, writes are refused with an error flag, and the map is left unchanged. The map and the counters are kept in the controller's own registers, apart from the user blocks.

Top module: `wl_mapper`

## Requirements
- R1: After reset, logical block j maps to physical block j. Blocks N_LOG to N_PHYS-1 are free. All erase counts are zero. `wr_ready` is 1, `cmd_valid` and `resp_valid` are 0, and `status` is 0.
- R2: An accepted write (`wr_valid` and `wr_ready` both 1 at a clock edge) takes the free block with the lowest erase count, with ties going to the lowest index. In the next cycle `resp_valid` is 1, `resp_err` is 0, `resp_pblk` holds that block, and a program command is issued with `cmd_dst` set to it.
- R3: The cycle after a program command carries an erase command whose `cmd_dst` is the block previously mapped to that logical block. The erase adds one to that block's count, and the block rejoins the free pool unless it has reached the limit.
- R4: After a write, the map entry points to the new block. The next write to the same logical block erases that new block.
- R5: `wr_ready` is 0 in every cycle that carries a program or copy command and in every cycle where a latched tick is pending. A request held during that time is taken once `wr_ready` returns to 1.
- R6: A `reloc_tick` pulse is latched. When the block is idle with a latched tick, it computes the gap between the highest count among free blocks (ties to the lowest index) and the lowest count among in-use blocks (ties to the lowest index). If the gap exceeds `gap_thresh`, the block issues a copy command from that in-use block to that free block, remaps the owning logical block, and follows one cycle later with an erase of the source. A latched tick is served ahead of a write.
- R7: A latched tick whose gap does not exceed `gap_thresh`, or that finds no free block, issues no command and clears the tick.
- R8: A block whose count reaches ENDURANCE (default 100000) on an erase is never chosen again, either by a write or by a relocation.
- R9: A write accepted while no free block exists returns `resp_valid`=1, `resp_err`=1 and `resp_pblk`=0. It issues no command and leaves the map unchanged.
- R10: Command encoding on `cmd_op` is 1 for program, 2 for erase and 3 for copy, and `cmd_src` is 0 except on copy. The bits of `status` are: bit 0 is set when no free block exists; bit 1 is set in the cycle that carries a copy command; bit 2 is set after a refused write and cleared by the next successful write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request can be taken |
| wr_lblk | input | LW | Logical block of the write |
| reloc_tick | input | 1 | Static relocation schedule pulse |
| gap_thresh | input | CW | Wear gap threshold for relocation |
| resp_valid | output | 1 | Write response pulse |
| resp_err | output | 1 | Write refused, no free block |
| resp_pblk | output | PW | Physical block chosen for the write |
| cmd_valid | output | 1 | Flash command pulse |
| cmd_op | output | 2 | Command: 1 program, 2 erase, 3 copy |
| cmd_src | output | PW | Copy source block |
| cmd_dst | output | PW | Target block of the command |
| status | output | 3 | {refused, relocating, no free block} |

## Verification
The bench drives writes skewed toward two logical blocks, so the other two go cold and relocation is forced. A block with wrong tie-breaking or a wrong gap comparison would then copy the wrong block or copy when it should not. The limit is lowered so blocks actually wear out. A design that reused a retired block would show up as a program command to a block at the limit, and a design that corrupted the map on a refused write would erase the wrong block later. Requests are held across the erase and relocation cycles, so a design that dropped or double-took a stalled request would show a response that does not match the model.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_COPY  = 2'd3
  } wl_op_e;

  typedef enum logic {
    S_IDLE  = 1'b0,
    S_ERASE = 1'b1
  } wl_state_e;
endpackage

// File: rtl/wl_rst_sync.sv
module wl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wl_pick.sv
module wl_pick #(
  parameter int N        = 8,
  parameter int CW       = 17,
  parameter int PW       = 3,
  parameter bit PICK_MAX = 1'b0
) (
  input  logic [N-1:0][CW-1:0] cnt,
  input  logic [N-1:0]         mask,
  output logic                 found,
  output logic [PW-1:0]        idx,
  output logic [CW-1:0]        val
);
  // strict comparison keeps the lowest index on equal counts
  always_comb begin
    found = 1'b0;
    idx   = '0;
    val   = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && (!found || (PICK_MAX ? (cnt[i] > val) : (cnt[i] < val)))) begin
        found = 1'b1;
        idx   = PW'(i);
        val   = cnt[i];
      end
    end
  end
endmodule

// File: rtl/wl_wear_bank.sv
module wl_wear_bank #(
  parameter int N     = 8,
  parameter int CW    = 17,
  parameter int PW    = 3,
  parameter int LIMIT = 100000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_en,
  input  logic [PW-1:0]        inc_idx,
  output logic [N-1:0][CW-1:0] cnt,
  output logic                 hit_limit
);
  logic [N-1:0][CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_en) begin
      cnt_q[inc_idx] <= cnt_q[inc_idx] + 1'b1;
    end
  end

  assign cnt       = cnt_q;
  assign hit_limit = ({1'b0, cnt_q[inc_idx]} + 1'b1) >= (CW+1)'(LIMIT);
endmodule

// File: rtl/wl_mapper.sv
module wl_mapper #(
  parameter int N_PHYS    = 8,
  parameter int N_LOG     = 4,
  parameter int ENDURANCE = 100000,
  localparam int PW = $clog2(N_PHYS),
  localparam int LW = $clog2(N_LOG),
  localparam int CW = $clog2(ENDURANCE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [LW-1:0] wr_lblk,
  input  logic          reloc_tick,
  input  logic [CW-1:0] gap_thresh,
  output logic          resp_valid,
  output logic          resp_err,
  output logic [PW-1:0] resp_pblk,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [PW-1:0] cmd_src,
  output logic [PW-1:0] cmd_dst,
  output logic [2:0]    status
);
  import wl_pkg::*;

  logic rst_i_n;
  wl_state_e state_q, state_d;
  logic [N_LOG-1:0][PW-1:0] map_q, map_d;
  logic [N_PHYS-1:0] free_q, free_d, used_mask;
  logic [PW-1:0] old_q, old_d;
  logic tick_q, tick_d, reloc_q, reloc_d, rej_q, rej_d;
  logic rv_q, rv_d, re_q, re_d, cv_q, cv_d;
  logic [PW-1:0] rp_q, rp_d, cs_q, cs_d, cd_q, cd_d;
  wl_op_e op_q, op_d;

  logic [N_PHYS-1:0][CW-1:0] cnt;
  logic inc_en, hit_limit;
  logic fmin_ok, fmax_ok, umin_ok, gap_ok;
  logic [PW-1:0] fmin_idx, fmax_idx, umin_idx;
  logic [CW-1:0] fmin_val, fmax_val, umin_val;
  logic [LW-1:0] owner;

  wl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  wl_wear_bank #(.N(N_PHYS), .CW(CW), .PW(PW), .LIMIT(ENDURANCE)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .inc_en(inc_en), .inc_idx(old_q),
    .cnt(cnt), .hit_limit(hit_limit));

  wl_pick #(.N(N_PHYS), .CW(CW), .PW(PW), .PICK_MAX(1'b0)) u_free_min (
    .cnt(cnt), .mask(free_q), .found(fmin_ok), .idx(fmin_idx), .val(fmin_val));
  wl_pick #(.N(N_PHYS), .CW(CW), .PW(PW), .PICK_MAX(1'b1)) u_free_max (
    .cnt(cnt), .mask(free_q), .found(fmax_ok), .idx(fmax_idx), .val(fmax_val));
  wl_pick #(.N(N_PHYS), .CW(CW), .PW(PW), .PICK_MAX(1'b0)) u_used_min (
    .cnt(cnt), .mask(used_mask), .found(umin_ok), .idx(umin_idx), .val(umin_val));

  always_comb begin
    used_mask = '0;
    owner     = '0;
    for (int j = 0; j < N_LOG; j++) begin
      used_mask[map_q[j]] = 1'b1;
      if (map_q[j] == umin_idx) owner = LW'(j);
    end
  end

  assign gap_ok = fmax_ok && umin_ok &&
                  ({1'b0, fmax_val} > ({1'b0, umin_val} + {1'b0, gap_thresh}));

  // next-state process
  always_comb begin
    state_d = state_q;  map_d = map_q;  free_d = free_q;  old_d = old_q;
    reloc_d = reloc_q;  rej_d = rej_q;  tick_d = tick_q | reloc_tick;
    rv_d = 1'b0;  re_d = re_q;  rp_d = rp_q;
    cv_d = 1'b0;  op_d = OP_NONE;  cs_d = '0;  cd_d = '0;
    inc_en = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (tick_q) begin
          tick_d = reloc_tick;
          if (gap_ok) begin
            cv_d = 1'b1;  op_d = OP_COPY;  cs_d = umin_idx;  cd_d = fmax_idx;
            map_d[owner] = fmax_idx;
            free_d[fmax_idx] = 1'b0;
            old_d = umin_idx;
            reloc_d = 1'b1;
            state_d = S_ERASE;
          end
        end else if (wr_valid) begin
          rv_d = 1'b1;
          if (fmin_ok) begin
            re_d = 1'b0;  rp_d = fmin_idx;  rej_d = 1'b0;
            cv_d = 1'b1;  op_d = OP_PROG;  cd_d = fmin_idx;
            old_d = map_q[wr_lblk];
            map_d[wr_lblk] = fmin_idx;
            free_d[fmin_idx] = 1'b0;
            state_d = S_ERASE;
          end else begin
            re_d = 1'b1;  rp_d = '0;  rej_d = 1'b1;
          end
        end
      end
      S_ERASE: begin
        cv_d = 1'b1;  op_d = OP_ERASE;  cd_d = old_q;
        inc_en = 1'b1;
        free_d[old_q] = !hit_limit;
        reloc_d = 1'b0;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= S_IDLE;
      for (int j = 0; j < N_LOG; j++) map_q[j] <= PW'(j);
      for (int p = 0; p < N_PHYS; p++) free_q[p] <= (p >= N_LOG);
      old_q <= '0;  tick_q <= 1'b0;  reloc_q <= 1'b0;  rej_q <= 1'b0;
      rv_q <= 1'b0;  re_q <= 1'b0;  rp_q <= '0;
      cv_q <= 1'b0;  op_q <= OP_NONE;  cs_q <= '0;  cd_q <= '0;
    end else begin
      state_q <= state_d;  map_q <= map_d;  free_q <= free_d;  old_q <= old_d;
      tick_q <= tick_d;  reloc_q <= reloc_d;  rej_q <= rej_d;
      rv_q <= rv_d;  re_q <= re_d;  rp_q <= rp_d;
      cv_q <= cv_d;  op_q <= op_d;  cs_q <= cs_d;  cd_q <= cd_d;
    end
  end

  assign wr_ready   = (state_q == S_IDLE) && !tick_q;
  assign resp_valid = rv_q;
  assign resp_err   = re_q;
  assign resp_pblk  = rp_q;
  assign cmd_valid  = cv_q;
  assign cmd_op     = op_q;
  assign cmd_src    = cs_q;
  assign cmd_dst    = cd_q;
  assign status     = {rej_q, reloc_q, ~|free_q};
endmodule

// File: rtl/wl_mapper_chk.sv
module wl_mapper_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          resp_valid,
  input logic          resp_err,
  input logic [PW-1:0] resp_pblk,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [PW-1:0] cmd_src,
  input logic [PW-1:0] cmd_dst,
  input logic [2:0]    status
);
  // R2
  resp_has_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_err) |-> (cmd_valid && cmd_op == 2'd1 && cmd_dst == resp_pblk));

  // R3
  prog_then_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1) |=> (cmd_valid && cmd_op == 2'd2));

  // R6
  copy_then_erase_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |=> (cmd_valid && cmd_op == 2'd2 && cmd_dst == $past(cmd_src)));

  // R5
  stall_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd3)) |-> !wr_ready);

  // R9
  refused_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> (!cmd_valid && status[0] && status[2]));

  // R10
  copy_flags_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |-> status[1]);
endmodule

bind wl_mapper wl_mapper_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .resp_valid(resp_valid),
  .resp_err(resp_err), .resp_pblk(resp_pblk), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .status(status));

// File: tb/wl_mapper_tb.sv
`timescale 1ns/1ps
module wl_mapper_tb;
  localparam int NP = 8, NL = 4, LIM = 12;
  localparam int PW = 3, LW = 2, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, reloc_tick = 1'b0;
  logic [LW-1:0] wr_lblk = '0;
  logic [CW-1:0] gap_thresh = '0;
  logic wr_ready, resp_valid, resp_err, cmd_valid;
  logic [PW-1:0] resp_pblk, cmd_src, cmd_dst;
  logic [1:0] cmd_op;
  logic [2:0] status;

  always #4 clk = ~clk;

  wl_mapper #(.N_PHYS(NP), .N_LOG(NL), .ENDURANCE(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_lblk(wr_lblk), .reloc_tick(reloc_tick), .gap_thresh(gap_thresh),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_pblk(resp_pblk),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_src(cmd_src),
    .cmd_dst(cmd_dst), .status(status));

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int n_copy = 0, n_refuse = 0, n_quiet_tick = 0;

  // bench model
  int m_cnt[NP];
  bit m_free[NP];
  int m_map[NL];
  int m_st, m_old;
  bit m_tick, m_reloc, m_rej;
  bit e_rv, e_re, e_cv;
  int e_rp, e_op, e_cs, e_cd;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin m_cnt[p] = 0; m_free[p] = (p >= NL); end
    for (int j = 0; j < NL; j++) m_map[j] = j;
    m_st = 0; m_old = 0; m_tick = 0; m_reloc = 0; m_rej = 0;
    e_rv = 0; e_re = 0; e_rp = 0; e_cv = 0; e_op = 0; e_cs = 0; e_cd = 0;
  endtask

  function automatic int pick(bit want_free, bit want_max);
    int best = -1;
    for (int p = 0; p < NP; p++) begin
      bit in_set = 0;
      if (want_free) in_set = m_free[p];
      else for (int j = 0; j < NL; j++) if (m_map[j] == p) in_set = 1;
      if (in_set && (best < 0 || (want_max ? m_cnt[p] > m_cnt[best] : m_cnt[p] < m_cnt[best])))
        best = p;
    end
    return best;
  endfunction

  function automatic bit no_free();
    for (int p = 0; p < NP; p++) if (m_free[p]) return 0;
    return 1;
  endfunction

  task automatic model_step(bit wv, int wl, bit tk, int th);
    e_rv = 0; e_cv = 0; e_op = 0; e_cs = 0; e_cd = 0;
    if (m_st == 0) begin
      if (m_tick) begin
        int fx, um;
        m_tick = tk;
        fx = pick(1, 1); um = pick(0, 0);
        if (fx >= 0 && um >= 0 && m_cnt[fx] > m_cnt[um] + th) begin
          e_cv = 1; e_op = 3; e_cs = um; e_cd = fx;
          for (int j = 0; j < NL; j++) if (m_map[j] == um) m_map[j] = fx;
          m_free[fx] = 0; m_old = um; m_reloc = 1; m_st = 1;
          n_copy++;
        end else n_quiet_tick++;
      end else begin
        m_tick = tk;
        if (wv) begin
          int fn;
          fn = pick(1, 0);
          e_rv = 1;
          if (fn >= 0) begin
            e_re = 0; e_rp = fn; m_rej = 0;
            e_cv = 1; e_op = 1; e_cd = fn;
            m_old = m_map[wl]; m_map[wl] = fn; m_free[fn] = 0; m_st = 1;
          end else begin
            e_re = 1; e_rp = 0; m_rej = 1; n_refuse++;
          end
        end
      end
    end else begin
      m_tick = m_tick | tk;
      e_cv = 1; e_op = 2; e_cd = m_old;
      m_cnt[m_old]++;
      m_free[m_old] = (m_cnt[m_old] < LIM);
      m_reloc = 0; m_st = 0;
    end
  endtask

  task automatic check_outputs();
    string ctag;
    chk("R5 ready", int'(wr_ready), int'(m_st == 0 && !m_tick));
    chk("R2 R9 resp_valid", int'(resp_valid), int'(e_rv));
    if (e_rv) begin
      chk(e_re ? "R9 resp_err" : "R2 resp_err", int'(resp_err), int'(e_re));
      chk(e_re ? "R9 resp_pblk" : "R2 resp_pblk", int'(resp_pblk), e_rp);
      if (!e_re) chk("R8 chosen block below limit", int'(m_cnt[resp_pblk] < LIM), 1);
    end
    case (e_op)
      1: ctag = "R2 program";
      2: ctag = "R3 R4 erase";
      3: ctag = "R6 copy";
      default: ctag = "R7 R9 no command";
    endcase
    chk({ctag, " cmd_valid"}, int'(cmd_valid), int'(e_cv));
    if (e_cv) begin
      chk({ctag, " R10 cmd_op"}, int'(cmd_op), e_op);
      chk({ctag, " cmd_src"}, int'(cmd_src), e_cs);
      chk({ctag, " cmd_dst"}, int'(cmd_dst), e_cd);
    end
    chk("R10 status", int'(status), int'({m_rej, m_reloc, no_free()}));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; reloc_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    // R1 reset state
    chk("R1 ready after reset", int'(wr_ready), 1);
    chk("R1 no command after reset", int'(cmd_valid), 0);
    chk("R1 no response after reset", int'(resp_valid), 0);
    chk("R1 status after reset", int'(status), 0);
  endtask

  // one cycle: check, drive, step
  task automatic cycle(bit wv, int wl, bit tk, int th);
    check_outputs();
    wr_valid = wv; wr_lblk = LW'(wl); reloc_tick = tk; gap_thresh = CW'(th);
    model_step(wv, wl, tk, th);
    @(negedge clk);
  endtask

  task automatic run_random(int cycles, int th_max);
    bit pend = 0;
    int wl = 0;
    int th = 0;
    for (int c = 0; c < cycles; c++) begin
      bit tk;
      bit acc;
      if (!pend && ($urandom % 10) < 6) begin
        pend = 1;
        wl = (($urandom % 10) < 8) ? int'($urandom % 2) : 2 + int'($urandom % 2);
      end
      if (($urandom % 64) == 0) th = int'($urandom % (th_max + 1));
      tk = (($urandom % 20) == 0);
      acc = pend && (m_st == 0) && !m_tick;
      cycle(pend, wl, tk, th);
      if (acc) pend = 0;
    end
    wr_valid = 1'b0; reloc_tick = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();
    // directed R2 R3 R4: first write to logical 0 lands in block 4, old block 0 erased
    cycle(1, 0, 0, 0);
    chk("R2 first write to lowest free index", int'(resp_pblk), 4);
    cycle(0, 0, 0, 0);
    chk("R3 erase of old block 0", int'(cmd_dst), 0);
    cycle(1, 0, 0, 0);
    chk("R2 R4 second write picks block 5", int'(resp_pblk), 5);
    cycle(0, 0, 0, 0);
    chk("R4 erase of block 4 from updated map", int'(cmd_dst), 4);
    // directed R7: tick with a large threshold does nothing
    cycle(0, 0, 1, 15);
    cycle(0, 0, 0, 15);
    cycle(0, 0, 0, 15);
    run_random(4000, 3);
    chk("R6 relocation occurred", int'(n_copy > 0), 1);
    chk("R9 refusal occurred", int'(n_refuse > 0), 1);
    chk("R7 quiet tick occurred", int'(n_quiet_tick > 0), 1);
    chk("R8 R10 pool exhausted", int'(status[0]), 1);
    do_reset();
    run_random(2000, 1);
    check_outputs();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule